// File: doc/BRIEF.md
# Cascaded CAM Response Arbiter

This block is the per-device control slice that lets several content-addressable memory devices be stacked in a vertical chain and behave as one larger memory. Each device takes a system match flag and a system full flag from the device before it. It combines them with its own local match and full indications and passes the result to the next device. The flags are active low and ripple through the chain with no external logic. The first device in the chain ties its inputs to "no match" and "full".

From these flags every device works out two facts. The first is whether it holds the highest-priority match in the system, which means it is the first device with a local match. The second is whether it owns the next free location, which means it is the first device that is not full. A page register gives each device its own upper result bits. A device-select register picks one device, or every device at once with the all-ones value. The block uses these to gate bus reads and writes, so that exactly one device answers for match-addressed and free-addressed operations. Register reads are refused while nothing in the system matches. The CAM array itself is represented by plain local match, full and address inputs.

Top module: `cascade_node`

## Requirements
- R1: `match_out_n` is low exactly when `match_in_n` is low or `loc_match` is high.
- R2: `full_out_n` is low exactly when `full_in_n` is low and `loc_full` is high.
- R3: A bus request with `bus_tgt` = 0 (match location) gets a response only from the device whose `match_in_n` is high and `loc_match` is high, and only when that device is selected. A read returns `{page[7:0], loc_match_addr}`.
- R4: A request with `bus_tgt` = 1 (free location) gets a response only from the device whose `full_in_n` is low and `loc_full` is low, and only when that device is selected. A read returns `{page[7:0], loc_free_addr}`, whether or not any device matches.
- R5: A device is selected when its device-select register equals its page register, or when the device-select register holds 16'hFFFF. A device that is not selected never responds to a request with `bus_tgt` = 0, 1, or to a read with `bus_tgt` = 2 or 3.
- R6: A write with `bus_tgt` = 3 loads `bus_wdata` into the device-select register of every device, whatever the selection. The register resets to 16'hFFFF.
- R7: A write with `bus_tgt` = 2 loads `bus_wdata` into the page register only in the free-location owner of R4, with no selection needed. The page register resets to 0.
- R8: A read with `bus_tgt` = 2 (page) or 3 (device select) is refused by every device while `chain_match_n` is high. With a match in the system, it is answered by a selected device when the device select equals its page, or, under the 16'hFFFF broadcast, only by the match owner.
- R9: `resp_en` and `rd_data` are registered and present the result one cycle after the request. `rd_data` is 0 for writes and for non-responding devices. A write acknowledged under R6 or R7 raises `resp_en`. Target codes 4 to 7 never get a response and change nothing.
- R10: After reset `resp_en` is 0 and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| match_in_n | input | 1 | System match from the previous device, active low |
| full_in_n | input | 1 | System full from the previous device, active low |
| chain_match_n | input | 1 | System match from the last device of the chain, active low |
| loc_match | input | 1 | Local array has a match |
| loc_full | input | 1 | Local array has no free location |
| loc_match_addr | input | LOC_W | Local highest-priority match address |
| loc_free_addr | input | LOC_W | Local next free address |
| bus_req | input | 1 | Bus cycle request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_tgt | input | 3 | Target: 0 match location, 1 free location, 2 page, 3 device select |
| bus_wdata | input | 16 | Write data |
| match_out_n | output | 1 | Qualified system match to the next device, active low |
| full_out_n | output | 1 | Qualified system full to the next device, active low |
| resp_en | output | 1 | This device answered the previous request |
| rd_data | output | 16 | Read result of the previous request |

## Verification
The bench chains four devices. It first loads distinct pages by making the lower devices full one step at a time. This catches a page write that lands in more than one device or in the wrong one. It drives broadcast and targeted selects while local matches are spread across several devices, so a priority rule that let a later matching device answer shows up as two responders on the bus. It checks free-location reads with no match anywhere and register reads under the same condition, which catches a design that blocks everything or nothing when the system has no match. It also runs the all-full chain, where no device may own the free location.

// File: rtl/cc_pkg.sv
package cc_pkg;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned TGT_W  = 3;
    localparam logic [DATA_W-1:0] DSEL_ALL = '1;

    typedef enum logic [TGT_W-1:0] {
        TGT_HPM  = 3'd0,
        TGT_NXF  = 3'd1,
        TGT_PAGE = 3'd2,
        TGT_DSEL = 3'd3
    } tgt_e;

    typedef struct packed {
        logic              req;
        logic              wr;
        logic [TGT_W-1:0]  tgt;
        logic [DATA_W-1:0] data;
    } bus_t;

    typedef struct packed {
        logic hp_owner;
        logic nf_owner;
        logic any_match;
    } own_t;

    function automatic logic dev_selected(input logic [DATA_W-1:0] dsel,
                                          input logic [DATA_W-1:0] page);
        return (dsel == DSEL_ALL) || (dsel == page);
    endfunction
endpackage

// File: rtl/cc_flag_chain.sv
module cc_flag_chain
    import cc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic match_in_n,
    input  logic full_in_n,
    input  logic chain_match_n,
    input  logic loc_match,
    input  logic loc_full,
    output logic match_out_n,
    output logic full_out_n,
    output own_t own
);
    always_comb begin
        match_out_n   = match_in_n & ~loc_match;
        full_out_n    = full_in_n | ~loc_full;
        own.hp_owner  = match_in_n & loc_match;
        own.nf_owner  = ~full_in_n & ~loc_full;
        own.any_match = ~chain_match_n;
    end

    // R2: a full indication may only pass on when it arrived
    assert_full_pass_R2: assert property (@(posedge clk) disable iff (rst)
        !full_out_n |-> !full_in_n);
    // R1: a local match always reaches the next device
    assert_match_pass_R1: assert property (@(posedge clk) disable iff (rst)
        loc_match |-> !match_out_n);
endmodule

// File: rtl/cc_regs.sv
module cc_regs
    import cc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_t              bus,
    input  logic              nf_owner,
    output logic [DATA_W-1:0] page,
    output logic [DATA_W-1:0] dsel
);
    logic wr_page, wr_dsel;

    always_comb begin
        wr_page = bus.req && bus.wr && (bus.tgt == TGT_PAGE) && nf_owner;
        wr_dsel = bus.req && bus.wr && (bus.tgt == TGT_DSEL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page <= '0;
            dsel <= DSEL_ALL;
        end else begin
            if (wr_page) page <= bus.data;
            if (wr_dsel) dsel <= bus.data;
        end
    end

    // R6: every device takes a device-select write
    assert_dsel_load_R6: assert property (@(posedge clk) disable iff (rst)
        (bus.req && bus.wr && bus.tgt == TGT_DSEL) |=> (dsel == $past(bus.data)));
    // R7: a page change needs free-location ownership
    assert_page_owner_R7: assert property (@(posedge clk) disable iff (rst)
        !nf_owner |=> $stable(page) || $past(rst));
endmodule

// File: rtl/cc_resp_gate.sv
module cc_resp_gate
    import cc_pkg::*;
#(
    parameter int unsigned LOC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_t              bus,
    input  own_t              own,
    input  logic [DATA_W-1:0] page,
    input  logic [DATA_W-1:0] dsel,
    input  logic [LOC_W-1:0]  loc_match_addr,
    input  logic [LOC_W-1:0]  loc_free_addr,
    output logic              resp_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned PG_W = DATA_W - LOC_W;

    logic              sel, reg_rd_ok, hit;
    logic [DATA_W-1:0] src;

    always_comb begin
        sel       = dev_selected(dsel, page);
        reg_rd_ok = sel && own.any_match && ((dsel == page) || own.hp_owner);
        hit       = 1'b0;
        src       = '0;
        case (bus.tgt)
            TGT_HPM: begin
                hit = sel && own.hp_owner;
                src = {page[PG_W-1:0], loc_match_addr};
            end
            TGT_NXF: begin
                hit = sel && own.nf_owner;
                src = {page[PG_W-1:0], loc_free_addr};
            end
            TGT_PAGE: begin
                hit = bus.wr ? own.nf_owner : reg_rd_ok;
                src = page;
            end
            TGT_DSEL: begin
                hit = bus.wr ? 1'b1 : reg_rd_ok;
                src = dsel;
            end
            default: begin
                hit = 1'b0;
                src = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_en <= 1'b0;
            rd_data <= '0;
        end else begin
            resp_en <= bus.req && hit;
            rd_data <= (bus.req && hit && !bus.wr) ? src : '0;
        end
    end

    // R3: only the first matching device answers a match-location cycle
    assert_hpm_owner_R3: assert property (@(posedge clk) disable iff (rst)
        (bus.req && bus.tgt == TGT_HPM && !own.hp_owner) |=> !resp_en);
    // R4: only the first non-full device answers a free-location cycle
    assert_nxf_owner_R4: assert property (@(posedge clk) disable iff (rst)
        (bus.req && bus.tgt == TGT_NXF && !own.nf_owner) |=> !resp_en);
    // R8: register reads are refused while the system has no match
    assert_read_block_R8: assert property (@(posedge clk) disable iff (rst)
        (bus.req && !bus.wr && (bus.tgt == TGT_PAGE || bus.tgt == TGT_DSEL)
         && !own.any_match) |=> !resp_en);
    // R9: write cycles never drive read data
    assert_wr_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (bus.req && bus.wr) |=> (rd_data == '0));
endmodule

// File: rtl/cascade_node.sv
module cascade_node
    import cc_pkg::*;
#(
    parameter int unsigned LOC_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              match_in_n,
    input  logic              full_in_n,
    input  logic              chain_match_n,
    input  logic              loc_match,
    input  logic              loc_full,
    input  logic [LOC_W-1:0]  loc_match_addr,
    input  logic [LOC_W-1:0]  loc_free_addr,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [2:0]        bus_tgt,
    input  logic [15:0]       bus_wdata,
    output logic              match_out_n,
    output logic              full_out_n,
    output logic              resp_en,
    output logic [15:0]       rd_data
);
    bus_t              bus;
    own_t              own;
    logic [DATA_W-1:0] page, dsel;

    always_comb begin
        bus.req  = bus_req;
        bus.wr   = bus_wr;
        bus.tgt  = bus_tgt;
        bus.data = bus_wdata;
    end

    cc_flag_chain u_flags (
        .clk(clk), .rst(rst),
        .match_in_n(match_in_n), .full_in_n(full_in_n),
        .chain_match_n(chain_match_n),
        .loc_match(loc_match), .loc_full(loc_full),
        .match_out_n(match_out_n), .full_out_n(full_out_n),
        .own(own)
    );

    cc_regs u_regs (
        .clk(clk), .rst(rst), .bus(bus), .nf_owner(own.nf_owner),
        .page(page), .dsel(dsel)
    );

    cc_resp_gate #(.LOC_W(LOC_W)) u_gate (
        .clk(clk), .rst(rst), .bus(bus), .own(own),
        .page(page), .dsel(dsel),
        .loc_match_addr(loc_match_addr), .loc_free_addr(loc_free_addr),
        .resp_en(resp_en), .rd_data(rd_data)
    );

    // R10: a reset cycle leaves the response idle
    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> (!resp_en && rd_data == '0));
endmodule

// File: tb/tb_cascade_node.sv
`timescale 1ns/1ps
module tb_cascade_node;
    localparam int N = 4;
    localparam int LOC_W = 8;

    logic clk = 1'b0;
    logic rst;
    always #2.5 clk = ~clk;

    logic bus_req, bus_wr;
    logic [2:0] bus_tgt;
    logic [15:0] bus_wdata;
    logic [N-1:0] lm, lf;
    logic [LOC_W-1:0] ma [N];
    logic [LOC_W-1:0] fa [N];
    logic [N:0] mch, fch;
    logic [N-1:0] resp;
    logic [15:0] rdd [N];

    logic [15:0] page_m [N];
    logic [15:0] dsel_m;
    int checks = 0, errors = 0;

    assign mch[0] = 1'b1;
    assign fch[0] = 1'b0;

    for (genvar gi = 0; gi < N; gi++) begin : g_dev
        cascade_node #(.LOC_W(LOC_W)) dut (
            .clk(clk), .rst(rst),
            .match_in_n(mch[gi]), .full_in_n(fch[gi]), .chain_match_n(mch[N]),
            .loc_match(lm[gi]), .loc_full(lf[gi]),
            .loc_match_addr(ma[gi]), .loc_free_addr(fa[gi]),
            .bus_req(bus_req), .bus_wr(bus_wr), .bus_tgt(bus_tgt), .bus_wdata(bus_wdata),
            .match_out_n(mch[gi+1]), .full_out_n(fch[gi+1]),
            .resp_en(resp[gi]), .rd_data(rdd[gi])
        );
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [N:0] exp_match_chain(input logic [N-1:0] m);
        logic [N:0] c;
        c[0] = 1'b1;
        for (int i = 0; i < N; i++) c[i+1] = c[i] && !m[i];
        return c;
    endfunction

    function automatic logic [N:0] exp_full_chain(input logic [N-1:0] f);
        logic [N:0] c;
        c[0] = 1'b0;
        for (int i = 0; i < N; i++) c[i+1] = c[i] || !f[i];
        return c;
    endfunction

    // Entered at a falling edge; returns at the falling edge after the response
    task automatic do_op(input logic wr, input logic [2:0] tgt, input logic [15:0] data);
        logic [N:0] em, ef;
        logic [N-1:0] er;
        logic [15:0] ed [N];
        logic sel, hp, nf, anym, regok;
        bus_req = 1'b1; bus_wr = wr; bus_tgt = tgt; bus_wdata = data;
        #1;
        em = exp_match_chain(lm);
        ef = exp_full_chain(lf);
        check("R1 match chain", 32'(mch), 32'(em));
        check("R2 full chain", 32'(fch), 32'(ef));
        anym = !em[N];
        for (int i = 0; i < N; i++) begin
            sel   = (dsel_m == 16'hFFFF) || (dsel_m == page_m[i]);
            hp    = em[i] && lm[i];
            nf    = !ef[i] && !lf[i];
            regok = sel && anym && ((dsel_m == page_m[i]) || hp);
            er[i] = 1'b0; ed[i] = 16'h0;
            case (tgt)
                3'd0: begin er[i] = sel && hp; ed[i] = {page_m[i][7:0], ma[i]}; end
                3'd1: begin er[i] = sel && nf; ed[i] = {page_m[i][7:0], fa[i]}; end
                3'd2: begin er[i] = wr ? nf : regok; ed[i] = page_m[i]; end
                3'd3: begin er[i] = wr ? 1'b1 : regok; ed[i] = dsel_m; end
                default: er[i] = 1'b0;
            endcase
            if (!er[i] || wr) ed[i] = 16'h0;
        end
        @(negedge clk);
        check($sformatf("R3 R4 R5 R8 R9 resp tgt=%0d wr=%0b", tgt, wr), 32'(resp), 32'(er));
        for (int i = 0; i < N; i++)
            check($sformatf("R3 R4 R8 R9 rd_data dev%0d tgt=%0d", i, tgt), 32'(rdd[i]), 32'(ed[i]));
        if (wr && tgt == 3'd3) dsel_m = data;
        if (wr && tgt == 3'd2)
            for (int i = 0; i < N; i++) if (!ef[i] && !lf[i]) page_m[i] = data;
        bus_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        rst = 1'b1; bus_req = 0; bus_wr = 0; bus_tgt = 0; bus_wdata = 0;
        lm = '0; lf = '0;
        for (int i = 0; i < N; i++) begin ma[i] = 8'(i * 17 + 3); fa[i] = 8'(i * 29 + 5); page_m[i] = 16'h0; end
        dsel_m = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        for (int i = 0; i < N; i++) begin
            check("R10 resp_en after reset", 32'(resp[i]), 32'h0);
            check("R10 rd_data after reset", 32'(rdd[i]), 32'h0);
        end
        rst = 1'b0;
        @(negedge clk);
        // R7: load pages one device at a time through the full chain
        for (int k = 0; k < N; k++) begin
            lf = N'((1 << k) - 1);
            do_op(1'b1, 3'd2, 16'h0010 + 16'(k));
        end
        lf = '0;
        // R5 R8: targeted page read with matches everywhere
        lm = '1;
        do_op(1'b1, 3'd3, 16'h0012);
        do_op(1'b0, 3'd2, 16'h0);
        do_op(1'b0, 3'd3, 16'h0);
        do_op(1'b0, 3'd0, 16'h0);   // R5: device 2 is not the match owner, no answer
        // R8: no match anywhere blocks register reads, R4 free read still allowed
        lm = '0;
        do_op(1'b1, 3'd3, 16'hFFFF);
        do_op(1'b0, 3'd2, 16'h0);
        do_op(1'b0, 3'd1, 16'h0);
        // R3: broadcast, matches at devices 1 and 2
        lm = 4'b0110;
        do_op(1'b0, 3'd0, 16'h0);
        do_op(1'b0, 3'd2, 16'h0);
        // R4: every device full, nobody owns the free location
        lf = '1;
        do_op(1'b0, 3'd1, 16'h0);
        do_op(1'b1, 3'd2, 16'hBEEF); // R7: page write lost
        lf = 4'b0011;
        do_op(1'b0, 3'd1, 16'h0);
        // R9: reserved targets
        do_op(1'b0, 3'd5, 16'h0);
        do_op(1'b1, 3'd7, 16'h1234);
        // R6: select a page that no device holds
        do_op(1'b1, 3'd3, 16'h0777);
        do_op(1'b0, 3'd0, 16'h0);
        do_op(1'b0, 3'd1, 16'h0);
        // random phase
        for (int it = 0; it < 400; it++) begin
            logic [2:0] t;
            logic w;
            logic [15:0] d;
            for (int i = 0; i < N; i++) begin
                lm[i] = ($urandom % 3) == 0;
                lf[i] = ($urandom % 2) == 0;
                ma[i] = 8'($urandom);
                fa[i] = 8'($urandom);
            end
            t = 3'($urandom % 5);
            if (($urandom % 10) == 0) t = 3'($urandom);
            w = ($urandom % 4) == 0;
            case ($urandom % 3)
                0: d = 16'hFFFF;
                1: d = page_m[$urandom % N];
                default: d = 16'($urandom);
            endcase
            if (t == 3'd2 && w && ($urandom % 4) != 0) w = 1'b0;
            do_op(w, t, d);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule